// File: doc/BRIEF.md
# DMA Read Request Splitter

This block sits between a DMA engine and the request path of a PCI Express transaction layer. The engine hands over one read job at a time, described by a start address and a byte count. The block cuts the job into consecutive memory read requests. No request is longer than the ceiling that the 3-bit maximum-read-request code selects. The payload-size setting plays no part in this limit. Each request leaves with an address, a length in dwords and a tag.

Tags come from a small pool that is held as a bitmap. A request is only presented when a tag is free, so the count of reads in flight can never exceed the pool size. A read can be answered by several completions, so a tag goes back to the pool only when the completion logic reports that the last completion for that tag has arrived. The job is finished when its final request has been issued and every tag it used has come back. At that point the block raises a one-cycle done pulse and accepts the next job.

Top module: `rd_req_splitter`

## Requirements
- R1: The size code selects the request ceiling in bytes. Code c in 0..5 gives 128·2^c, so 000 gives 128 and 101 gives 4096. Codes 110 and 111 give 128.
- R2: Every request length, given in dwords, is nonzero and no larger than the ceiling. All requests of a job except the last are exactly the ceiling, and the last carries the remainder. The job length must be a multiple of 4 bytes.
- R3: The first request of a job carries the job address. Each later request carries the previous request's address plus the previous request's length in bytes.
- R4: The size code is captured when the job is accepted. Changing it while the job runs has no effect on that job's requests.
- R5: Each request carries the lowest-numbered tag that is not outstanding. An outstanding tag is never presented.
- R6: While every tag is outstanding, req_valid is low. A tag returned at a clock edge can be reissued in the cycle after that edge.
- R7: A tag return naming a tag that is not outstanding is ignored. This also holds when it names the tag being allocated at the same edge.
- R8: job_done is high for exactly one cycle. It rises once the last request has been issued and all tags have returned. A zero-length job completes at once. job_ready is high only while no job is in progress.
- R9: While req_valid is high and req_ready is low, req_addr, req_len_dw and req_tag hold their values until the handshake.
- R10: After reset, job_ready is 1, and req_valid and job_done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_valid | input | 1 | Job descriptor offered |
| job_ready | output | 1 | Block is idle and will take a job |
| job_addr | input | ADDR_W | Job start byte address |
| job_len | input | LEN_W | Job length in bytes, a multiple of 4 |
| rd_size_code | input | 3 | Maximum read request size code |
| req_valid | output | 1 | Request descriptor valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | ADDR_W | Request byte address |
| req_len_dw | output | 11 | Request length in dwords |
| req_tag | output | TAG_W | Tag given to the request |
| tag_ret_valid | input | 1 | Last completion seen for a tag |
| tag_ret_tag | input | TAG_W | Tag being returned |
| job_done | output | 1 | One-cycle pulse when the job is complete |

## Verification
Tag allocation and tag return can fall on the same clock edge. When they do, the pool must keep the newly allocated tag busy and free the returned one. It must also ignore a stray return that names the tag being handed out. The bench provokes this in two ways. In one run it returns the lowest outstanding tag on every cycle while requests keep flowing. In another it sends a stray return for exactly the tag about to be allocated. A bench-side bitmap model then predicts the tag of every later request and the cycle of the done pulse.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } rrs_state_e;

  localparam int unsigned CAP_W = 13;

  // Ceiling in bytes for a size code; reserved codes fall back to the minimum.
  function automatic logic [CAP_W-1:0] rrs_code_to_bytes(input logic [2:0] code);
    logic [CAP_W-1:0] v;
    case (code)
      3'd0: v = 13'd128;
      3'd1: v = 13'd256;
      3'd2: v = 13'd512;
      3'd3: v = 13'd1024;
      3'd4: v = 13'd2048;
      3'd5: v = 13'd4096;
      default: v = 13'd128;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rrs_size_decode.sv
module rrs_size_decode
  import rrs_pkg::*;
(
  input  logic [2:0]       code,
  output logic [CAP_W-1:0] max_bytes
);
  always_comb max_bytes = rrs_code_to_bytes(code);
endmodule

// File: rtl/rrs_tag_pool.sv
module rrs_tag_pool #(
  parameter int unsigned NTAGS = 8,
  parameter int unsigned TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             rel_en,
  input  logic [TAG_W-1:0] rel_tag,
  output logic [NTAGS-1:0] busy,
  output logic [TAG_W-1:0] low_free,
  output logic             free_any,
  output logic             pool_empty
);
  logic [NTAGS-1:0] busy_q;
  logic [NTAGS-1:0] alloc_mask;
  logic [NTAGS-1:0] rel_mask;

  always_comb begin
    alloc_mask = alloc_en ? (NTAGS'(1) << alloc_tag) : '0;
    // a return only clears a tag that is outstanding before this edge
    rel_mask   = rel_en ? ((NTAGS'(1) << rel_tag) & busy_q) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q & ~rel_mask) | alloc_mask;
  end

  // scan downward so the last hit is the lowest free index
  always_comb begin
    low_free = '0;
    for (int i = NTAGS - 1; i >= 0; i--) begin
      if (!busy_q[i]) low_free = TAG_W'(i);
    end
  end

  assign busy       = busy_q;
  assign free_any   = ~&busy_q;
  assign pool_empty = ~|busy_q;
endmodule

// File: rtl/rrs_issue_ctrl.sv
module rrs_issue_ctrl
  import rrs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              job_valid,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [LEN_W-1:0]  job_len,
  input  logic [CAP_W-1:0]  max_bytes_in,
  input  logic              free_any,
  input  logic              pool_empty,
  input  logic [TAG_W-1:0]  low_free,
  input  logic              req_ready,
  output logic              job_ready,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [10:0]       req_len_dw,
  output logic [TAG_W-1:0]  req_tag,
  output logic              alloc_en,
  output logic              job_done,
  output logic              job_active,
  output logic [CAP_W-1:0]  cur_max
);
  rrs_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [CAP_W-1:0]  cap_q;
  logic              pend_q;
  logic [TAG_W-1:0]  pend_tag_q;
  logic [CAP_W-1:0]  chunk;
  logic              handshake;

  always_comb begin
    chunk = (rem_q < LEN_W'(cap_q)) ? rem_q[CAP_W-1:0] : cap_q;
  end

  assign req_valid  = (state_q == ST_ISSUE) && (pend_q || free_any);
  assign req_tag    = pend_q ? pend_tag_q : low_free;
  assign req_addr   = addr_q;
  assign req_len_dw = chunk[CAP_W-1:2];
  assign handshake  = req_valid && req_ready;
  assign alloc_en   = handshake;
  assign job_ready  = (state_q == ST_IDLE);
  assign job_done   = (state_q == ST_DRAIN) && pool_empty;
  assign job_active = (state_q != ST_IDLE);
  assign cur_max    = cap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      rem_q      <= '0;
      cap_q      <= 13'd128;
      pend_q     <= 1'b0;
      pend_tag_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (job_valid) begin
            addr_q  <= job_addr;
            rem_q   <= job_len;
            cap_q   <= max_bytes_in;
            pend_q  <= 1'b0;
            state_q <= (job_len == '0) ? ST_DRAIN : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (handshake) begin
            addr_q <= addr_q + ADDR_W'(chunk);
            rem_q  <= rem_q - LEN_W'(chunk);
            pend_q <= 1'b0;
            if (rem_q == LEN_W'(chunk)) state_q <= ST_DRAIN;
          end else if (req_valid) begin
            pend_q     <= 1'b1;
            pend_tag_q <= req_tag;
          end
        end
        ST_DRAIN: begin
          if (pool_empty) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rd_req_splitter.sv
module rd_req_splitter
  import rrs_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned NTAGS  = 8,
  localparam int unsigned TAG_W = (NTAGS > 1) ? $clog2(NTAGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              job_valid,
  output logic              job_ready,
  input  logic [ADDR_W-1:0] job_addr,
  input  logic [LEN_W-1:0]  job_len,
  input  logic [2:0]        rd_size_code,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [10:0]       req_len_dw,
  output logic [TAG_W-1:0]  req_tag,
  input  logic              tag_ret_valid,
  input  logic [TAG_W-1:0]  tag_ret_tag,
  output logic              job_done
);
  // named internal events, observed by the bound checker
  logic [CAP_W-1:0] dec_max;
  logic [CAP_W-1:0] cur_max;
  logic [NTAGS-1:0] tag_busy;
  logic [TAG_W-1:0] low_free;
  logic             free_any;
  logic             pool_empty;
  logic             alloc_en;
  logic             job_active;

  rrs_size_decode u_dec (
    .code      (rd_size_code),
    .max_bytes (dec_max)
  );

  rrs_tag_pool #(.NTAGS(NTAGS), .TAG_W(TAG_W)) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (alloc_en),
    .alloc_tag  (req_tag),
    .rel_en     (tag_ret_valid),
    .rel_tag    (tag_ret_tag),
    .busy       (tag_busy),
    .low_free   (low_free),
    .free_any   (free_any),
    .pool_empty (pool_empty)
  );

  rrs_issue_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W)) u_issue (
    .clk          (clk),
    .rst_n        (rst_n),
    .job_valid    (job_valid),
    .job_addr     (job_addr),
    .job_len      (job_len),
    .max_bytes_in (dec_max),
    .free_any     (free_any),
    .pool_empty   (pool_empty),
    .low_free     (low_free),
    .req_ready    (req_ready),
    .job_ready    (job_ready),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_len_dw   (req_len_dw),
    .req_tag      (req_tag),
    .alloc_en     (alloc_en),
    .job_done     (job_done),
    .job_active   (job_active),
    .cur_max      (cur_max)
  );
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned NTAGS  = 8,
  parameter int unsigned TAG_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              job_valid,
  input logic              job_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [10:0]       req_len_dw,
  input logic [TAG_W-1:0]  req_tag,
  input logic              job_done,
  input logic [NTAGS-1:0]  tag_busy,
  input logic [12:0]       cur_max,
  input logic              job_active
);
  logic              seq_q;
  logic [ADDR_W-1:0] next_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q       <= 1'b0;
      next_addr_q <= '0;
    end else if (job_valid && job_ready) begin
      seq_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      seq_q       <= 1'b1;
      next_addr_q <= req_addr + ADDR_W'({req_len_dw, 2'b00});
    end
  end

  assert_len_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len_dw != 11'd0) && ({req_len_dw, 2'b00} <= cur_max));

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && seq_q) |-> (req_addr == next_addr_q));

  assert_size_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (job_active && $past(job_active)) |-> $stable(cur_max));

  assert_tag_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !((tag_busy >> req_tag) & NTAGS'(1)));

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&tag_busy) |-> !req_valid);

  assert_done_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |-> (tag_busy == '0) && !job_ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> !job_done);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr)
      && $stable(req_len_dw) && $stable(req_tag));
endmodule

bind rd_req_splitter rrs_checker #(.ADDR_W(ADDR_W), .NTAGS(NTAGS), .TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .job_valid  (job_valid),
  .job_ready  (job_ready),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_len_dw (req_len_dw),
  .req_tag    (req_tag),
  .job_done   (job_done),
  .tag_busy   (tag_busy),
  .cur_max    (cur_max),
  .job_active (job_active)
);

// File: tb/tb_rd_req_splitter.sv
module tb_rd_req_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int NTAGS  = 4;
  localparam int TAG_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              job_valid = 1'b0;
  logic              job_ready;
  logic [ADDR_W-1:0] job_addr = '0;
  logic [LEN_W-1:0]  job_len = '0;
  logic [2:0]        rd_size_code = '0;
  logic              req_valid;
  logic              req_ready = 1'b0;
  logic [ADDR_W-1:0] req_addr;
  logic [10:0]       req_len_dw;
  logic [TAG_W-1:0]  req_tag;
  logic              tag_ret_valid = 1'b0;
  logic [TAG_W-1:0]  tag_ret_tag = '0;
  logic              job_done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rd_req_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NTAGS(NTAGS)) dut (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_addr(job_addr), .job_len(job_len), .rd_size_code(rd_size_code),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len_dw(req_len_dw), .req_tag(req_tag), .tag_ret_valid(tag_ret_valid),
    .tag_ret_tag(tag_ret_tag), .job_done(job_done)
  );

  task automatic check(input string rq, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic int ceiling_bytes(input int code);
    int v = 128;
    if (code > 5) return 128;
    for (int k = 0; k < code; k++) v = v * 2;
    return v;
  endfunction

  function automatic int first_clear(input logic [NTAGS-1:0] m);
    int k = 0;
    while (k < NTAGS && m[k]) k++;
    return k;
  endfunction

  // rel_mode 0: return lowest outstanding tag every cycle
  // rel_mode 1: return only when pool full for 2 cycles or all issued
  // rel_mode 2: as 1, plus stray returns of the tag about to be allocated
  // ready_mode 0: always ready, 1: ready on two of three cycles
  task automatic run_job(input string rq, input logic [31:0] addr, input int len,
                         input int code, input int code_mid,
                         input int ready_mode, input int rel_mode);
    logic [31:0]      eaddr = addr;
    int               erem = len;
    int               cap = ceiling_bytes(code);
    logic [NTAGS-1:0] mbusy = '0;
    bit               held = 0;
    int               htag = 0;
    int               full_cnt = 0;
    bit               done_seen = 0;
    @(negedge clk);
    job_addr = addr; job_len = LEN_W'(len); rd_size_code = 3'(code); job_valid = 1'b1;
    #1 check("R8", "job_ready idle", job_ready, 1);
    @(posedge clk);
    @(negedge clk);
    job_valid = 1'b0;
    rd_size_code = 3'(code_mid);
    for (int cyc = 0; cyc < 3000; cyc++) begin
      bit full;
      bit rel_v;
      int rel_t;
      bit exp_valid;
      int exp_tag;
      int chunk;
      logic [NTAGS-1:0] relm;
      logic [NTAGS-1:0] allocm;
      full = (mbusy == {NTAGS{1'b1}});
      req_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 2);
      rel_v = 0; rel_t = 0;
      if (rel_mode == 0) begin
        if (mbusy != '0) begin rel_v = 1; rel_t = first_clear(~mbusy); end
      end else begin
        if (full) full_cnt++; else full_cnt = 0;
        if ((full && full_cnt > 2) || (erem == 0 && mbusy != '0)) begin
          rel_v = 1; rel_t = first_clear(~mbusy);
        end else if (rel_mode == 2 && !full) begin
          rel_v = 1; rel_t = held ? htag : first_clear(mbusy);
        end
      end
      tag_ret_valid = rel_v;
      tag_ret_tag = TAG_W'(rel_t);
      #1;
      exp_valid = (erem > 0) && (held || !full);
      check(full ? "R6" : "R2", "req_valid", req_valid, exp_valid);
      check("R8", "job_ready busy", job_ready, 0);
      exp_tag = held ? htag : first_clear(mbusy);
      chunk = (erem < cap) ? erem : cap;
      if (exp_valid) begin
        check(code != code_mid ? "R4" : "R2", "req_len_dw", req_len_dw, chunk / 4);
        check("R3", "req_addr", req_addr, eaddr);
        check(held ? "R9" : "R5", "req_tag", req_tag, exp_tag);
      end
      check("R8", "job_done", job_done, (erem == 0 && mbusy == '0));
      if (erem == 0 && mbusy == '0) begin done_seen = 1; break; end
      allocm = '0;
      if (exp_valid && req_ready) begin
        allocm = NTAGS'(1) << exp_tag;
        eaddr = eaddr + 32'(chunk);
        erem = erem - chunk;
        held = 0;
      end else if (exp_valid) begin
        held = 1; htag = exp_tag;
      end
      relm = rel_v ? ((NTAGS'(1) << rel_t) & mbusy) : '0;
      mbusy = (mbusy & ~relm) | allocm;
      @(posedge clk);
      @(negedge clk);
    end
    check(rq, "job completed", done_seen, 1);
    tag_ret_valid = 1'b0;
    req_ready = 1'b0;
    @(posedge clk);
    #1;
    check("R8", "done pulse one cycle", job_done, 0);
    check("R8", "job_ready after done", job_ready, 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "job_ready", job_ready, 1);
    check("R10", "req_valid", req_valid, 0);
    check("R10", "job_done", job_done, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_code_sweep();
    for (int c = 0; c < 8; c++) run_job("R1", 32'h0001_0000, 5000, c, c, 0, 0);
  endtask

  task automatic t_remainder();
    run_job("R2", 32'h0000_2000, 300, 0, 0, 0, 0);
    run_job("R2", 32'h0000_4004, 2052, 3, 3, 0, 1);
  endtask

  task automatic t_code_change();
    run_job("R4", 32'h0003_0000, 1800, 1, 5, 0, 0);
  endtask

  task automatic t_stall();
    run_job("R6", 32'h0000_8000, 128 * 10, 0, 0, 0, 1);
  endtask

  task automatic t_stray_return();
    run_job("R7", 32'h0000_9000, 128 * 9, 0, 0, 0, 2);
    run_job("R7", 32'h0000_A000, 256 * 7, 1, 1, 1, 2);
  endtask

  task automatic t_backpressure();
    run_job("R9", 32'h0005_0000, 512 * 6, 2, 2, 1, 0);
    run_job("R9", 32'h0006_0000, 128 * 8, 0, 0, 1, 1);
  endtask

  task automatic t_zero_len();
    run_job("R8", 32'h0000_0040, 0, 2, 2, 0, 0);
  endtask

  initial begin
    t_reset();
    t_code_sweep();
    t_remainder();
    t_code_change();
    t_stall();
    t_stray_return();
    t_backpressure();
    t_zero_len();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule